// File: doc/BRIEF.md
# Exception Request Latch and Vector Selector

This block sits beside the instruction sequencer of a small microcoded processor core. It collects the three exception requests: the reset line, the edge-triggered non-maskable interrupt and the level-triggered maskable interrupt. At each instruction boundary, marked by the opcode-load strobe, it decides whether an exception must run instead of the fetched instruction. When one is taken, it raises an exception-active flag and presents a 3-bit alternate opcode built from the active-low request bits. The sequencer uses that opcode in place of the fetched one. In the same cycle the block blocks the program-counter increment, so the interrupted address is the one the handler saves.

Each request bit is active low. Bit 0 is reset, bit 1 is the non-maskable interrupt and bit 2 is the maskable interrupt. The microcode therefore sees a distinct code for each combination of requests, and it picks the handler from those codes. While the reset line is low, the core is held and the block forces the reset code. The microcode raises an acknowledge strobe once the handler entry sequence is done, and the exception flag then drops at the following boundary. The low byte of the vector address is formed from a fixed high nibble and a 4-bit code that the microcode supplies.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After the block reset, exc_active is 0, alt_op is 3'b111, pc_inc_inhibit is 0 and core_hold is 0.
- R2: While the synchronised reset request is low, core_hold is 1, exc_active is 1 and alt_op is 3'b110. After the reset request returns high, core_hold drops and exc_active stays 1 with alt_op 3'b110 without any opcode load.
- R3: A falling edge on nmi_n makes a non-maskable request. A low level held on nmi_n after its request has been serviced makes no new request.
- R4: A non-maskable request stays pending for any number of cycles until an opcode load takes it.
- R5: A low irq_n is taken at an opcode load only when irq_mask is 0, and gives alt_op 3'b011. With irq_mask at 1, exc_active stays 0.
- R6: If a non-maskable request and an enabled maskable request are both present at an opcode load, alt_op is 3'b001.
- R7: pc_inc_inhibit is 1 only during an opcode load at which an exception is entered. It is 0 during an ordinary opcode load.
- R8: Once set, exc_active survives opcode loads until exc_ack has been seen. The first opcode load after the acknowledge clears it to alt_op 3'b111 if no request is present.
- R9: A non-maskable request that arrives after a maskable handler has been acknowledged is taken at the next opcode load, with alt_op 3'b101 while irq_mask is 1.
- R10: vec_lo equals the high nibble 4'hF joined with vec_code. This gives 8'hFC, 8'hFA and 8'hFE for codes 4'hC, 4'hA and 4'hE.
- R11: exc_ack clears the reset request, so the reset handler is not entered again after its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| cpu_rst_n | input | 1 | Active-low core reset request line |
| nmi_n | input | 1 | Active-low non-maskable interrupt, falling-edge sensitive |
| irq_n | input | 1 | Active-low maskable interrupt, level sensitive |
| irq_mask | input | 1 | Interrupt-disable flag, 1 blocks irq_n |
| op_load | input | 1 | One-cycle opcode-load strobe marking an instruction boundary |
| exc_ack | input | 1 | Acknowledge from the handler entry microcode |
| vec_code | input | 4 | Low nibble of the vector address |
| core_hold | output | 1 | Core is held in reset |
| exc_active | output | 1 | An exception sequence is executing |
| alt_op | output | 3 | Alternate opcode: {irq, nmi, reset} request bits, active low |
| pc_inc_inhibit | output | 1 | Blocks the program-counter increment at exception entry |
| vec_lo | output | 8 | Low byte of the vector address |

## Verification
The hardest case to reach is a non-maskable edge that arrives while a maskable handler is already running. To create it, the maskable exception must be entered and acknowledged, the mask flag set as the handler would set it, and irq_n kept low. A falling edge on nmi_n is then issued before the next opcode load. The bench walks through exactly this order. It also checks that the pending edge is consumed by that load, so a later load with nmi_n still low finds nothing to take. The reset case is driven the same way: the handler is entered, then loads are given both before and after the acknowledge.

// File: rtl/exc_pkg.sv
package exc_pkg;

    // Alternate opcode bit order: {irq_n, nmi_n, res_n}, each active low
    typedef struct packed {
        logic irq_n;
        logic nmi_n;
        logic res_n;
    } exc_bits_t;

    localparam exc_bits_t ALT_IDLE  = '{irq_n: 1'b1, nmi_n: 1'b1, res_n: 1'b1};
    localparam exc_bits_t ALT_RESET = '{irq_n: 1'b1, nmi_n: 1'b1, res_n: 1'b0};

    function automatic exc_bits_t pack_req(input logic res, input logic nmi,
                                           input logic irq);
        exc_bits_t b;
        b.res_n = ~res;
        b.nmi_n = ~nmi;
        b.irq_n = ~irq;
        return b;
    endfunction

    function automatic logic any_req(input exc_bits_t b);
        return ~&b;
    endfunction

endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stg[i] <= '1;
            end else if (i == 0) begin
                stg[i] <= din;
            end else begin
                stg[i] <= stg[(i > 0) ? i - 1 : 0];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/exc_nmi_edge.sv
module exc_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi_s_n,
    input  logic hold,
    input  logic consume,
    output logic pending
);
    logic prev_n;
    logic fall;

    assign fall = prev_n & ~nmi_s_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n  <= 1'b1;
            pending <= 1'b0;
        end else begin
            prev_n <= nmi_s_n;
            if (hold) begin
                pending <= 1'b0;
            end else if (fall) begin
                pending <= 1'b1;
            end else if (consume) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold,
    input  logic      nmi_pend,
    input  logic      irq_act,
    input  logic      op_load,
    input  logic      exc_ack,
    output logic      exc_active,
    output exc_bits_t alt_op,
    output logic      inhibit,
    output logic      nmi_consume
);
    logic      exc_q;
    logic      acked_q;
    logic      res_req_q;
    exc_bits_t alt_q;
    exc_bits_t req;
    logic      open_win;
    logic      take;

    assign req         = pack_req(res_req_q, nmi_pend, irq_act);
    assign open_win    = ~exc_q | acked_q;
    assign take        = op_load & open_win & any_req(req) & ~hold;
    assign inhibit     = take;
    assign nmi_consume = take & nmi_pend & ~res_req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            exc_q     <= 1'b0;
            acked_q   <= 1'b0;
            res_req_q <= 1'b0;
            alt_q     <= ALT_IDLE;
        end else if (hold) begin
            exc_q     <= 1'b1;
            acked_q   <= 1'b0;
            res_req_q <= 1'b1;
            alt_q     <= ALT_RESET;
        end else begin
            if (exc_ack) begin
                acked_q   <= 1'b1;
                res_req_q <= 1'b0;
            end
            if (op_load && open_win) begin
                exc_q   <= any_req(req);
                alt_q   <= any_req(req) ? req : ALT_IDLE;
                acked_q <= 1'b0;
            end
        end
    end

    assign exc_active = exc_q;
    assign alt_op     = alt_q;
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen #(
    parameter logic [3:0] VEC_HI = 4'hF
) (
    input  logic [3:0] vec_code,
    output logic [7:0] vec_lo
);
    assign vec_lo = {VEC_HI, vec_code};
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl
    import exc_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] VEC_HI      = 4'hF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_rst_n,
    input  logic       nmi_n,
    input  logic       irq_n,
    input  logic       irq_mask,
    input  logic       op_load,
    input  logic       exc_ack,
    input  logic [3:0] vec_code,
    output logic       core_hold,
    output logic       exc_active,
    output logic [2:0] alt_op,
    output logic       pc_inc_inhibit,
    output logic [7:0] vec_lo
);
    localparam int NLINES = 3;

    logic [NLINES-1:0] lines_s;
    logic              nmi_pend;
    logic              nmi_consume;
    logic              irq_act;
    exc_bits_t         alt_bits;

    exc_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({irq_n, nmi_n, cpu_rst_n}),
        .dout(lines_s)
    );

    assign core_hold = ~lines_s[0];
    assign irq_act   = ~lines_s[2] & ~irq_mask;

    exc_nmi_edge u_nmi (
        .clk    (clk),
        .rst    (rst),
        .nmi_s_n(lines_s[1]),
        .hold   (core_hold),
        .consume(nmi_consume),
        .pending(nmi_pend)
    );

    exc_entry_ctrl u_entry (
        .clk        (clk),
        .rst        (rst),
        .hold       (core_hold),
        .nmi_pend   (nmi_pend),
        .irq_act    (irq_act),
        .op_load    (op_load),
        .exc_ack    (exc_ack),
        .exc_active (exc_active),
        .alt_op     (alt_bits),
        .inhibit    (pc_inc_inhibit),
        .nmi_consume(nmi_consume)
    );

    assign alt_op = alt_bits;

    exc_vec_gen #(.VEC_HI(VEC_HI)) u_vec (
        .vec_code(vec_code),
        .vec_lo  (vec_lo)
    );
endmodule

// File: rtl/exc_vector_ctrl_chk.sv
module exc_vector_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_load,
    input logic       core_hold,
    input logic       exc_active,
    input logic [2:0] alt_op,
    input logic       pc_inc_inhibit
);
    p_inhibit_on_load_r7: assert property (@(posedge clk) disable iff (rst)
        pc_inc_inhibit |-> op_load);

    p_inhibit_enters_r7: assert property (@(posedge clk) disable iff (rst)
        pc_inc_inhibit |=> exc_active);

    p_hold_forces_reset_r2: assert property (@(posedge clk) disable iff (rst)
        core_hold |=> (exc_active && alt_op == 3'b110));

    p_exit_at_load_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(exc_active) |-> $past(op_load));

    p_alt_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!op_load && !core_hold) |=> $stable(alt_op));

    p_alt_has_req_r6: assert property (@(posedge clk) disable iff (rst)
        exc_active |-> alt_op != 3'b111);
endmodule

bind exc_vector_ctrl exc_vector_ctrl_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .op_load       (op_load),
    .core_hold     (core_hold),
    .exc_active    (exc_active),
    .alt_op        (alt_op),
    .pc_inc_inhibit(pc_inc_inhibit)
);

// File: tb/exc_vector_ctrl_bench.sv
module exc_vector_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_rst_n = 1'b1;
    logic       nmi_n = 1'b1;
    logic       irq_n = 1'b1;
    logic       irq_mask = 1'b0;
    logic       op_load = 1'b0;
    logic       exc_ack = 1'b0;
    logic [3:0] vec_code = 4'h0;
    logic       core_hold;
    logic       exc_active;
    logic [2:0] alt_op;
    logic       pc_inc_inhibit;
    logic [7:0] vec_lo;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_vector_ctrl u_exc_vector_ctrl (
        .clk(clk), .rst(rst), .cpu_rst_n(cpu_rst_n), .nmi_n(nmi_n),
        .irq_n(irq_n), .irq_mask(irq_mask), .op_load(op_load),
        .exc_ack(exc_ack), .vec_code(vec_code), .core_hold(core_hold),
        .exc_active(exc_active), .alt_op(alt_op),
        .pc_inc_inhibit(pc_inc_inhibit), .vec_lo(vec_lo)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulses op_load for one cycle; returns pc_inc_inhibit seen during it
    task automatic load(output logic inh);
        @(negedge clk);
        op_load = 1'b1;
        #1 inh = pc_inc_inhibit;
        @(negedge clk);
        op_load = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk);
        exc_ack = 1'b1;
        @(negedge clk);
        exc_ack = 1'b0;
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(3);
        chk("R1 exc_active", exc_active, 0);
        chk("R1 alt_op", alt_op, 3'b111);
        chk("R1 inhibit", pc_inc_inhibit, 0);
        chk("R1 core_hold", core_hold, 0);
    endtask

    task automatic t_reset_hold();
        logic inh;
        cpu_rst_n = 1'b0;
        tick(5);
        chk("R2 hold", core_hold, 1);
        chk("R2 exc in hold", exc_active, 1);
        chk("R2 alt in hold", alt_op, 3'b110);
        cpu_rst_n = 1'b1;
        tick(5);
        chk("R2 hold released", core_hold, 0);
        chk("R2 exc after release", exc_active, 1);
        chk("R2 alt after release", alt_op, 3'b110);
        load(inh);
        chk("R8 exc kept before ack", exc_active, 1);
        chk("R8 no inhibit before ack", inh, 0);
        ack();
        chk("R8 exc kept until load", exc_active, 1);
        load(inh);
        chk("R11 reset not re-entered", exc_active, 0);
        chk("R11 alt idle", alt_op, 3'b111);
        chk("R7 plain load no inhibit", inh, 0);
    endtask

    task automatic t_irq_and_nested_nmi();
        logic inh;
        irq_n = 1'b0;
        irq_mask = 1'b1;
        tick(4);
        load(inh);
        chk("R5 masked no entry", exc_active, 0);
        chk("R5 masked no inhibit", inh, 0);
        irq_mask = 1'b0;
        load(inh);
        chk("R7 inhibit at entry", inh, 1);
        chk("R5 irq entry", exc_active, 1);
        chk("R5 irq alt", alt_op, 3'b011);
        ack();
        irq_mask = 1'b1;
        nmi_n = 1'b0;
        tick(4);
        load(inh);
        chk("R9 nmi during irq", exc_active, 1);
        chk("R9 nmi alt", alt_op, 3'b101);
        chk("R9 inhibit", inh, 1);
        ack();
        load(inh);
        chk("R8 exit after ack", exc_active, 0);
        nmi_n = 1'b1;
        irq_n = 1'b1;
        irq_mask = 1'b0;
        tick(4);
    endtask

    task automatic t_nmi_pending();
        logic inh;
        nmi_n = 1'b0;
        tick(2);
        nmi_n = 1'b1;
        tick(12);
        chk("R4 no entry without load", exc_active, 0);
        load(inh);
        chk("R4 pending taken", exc_active, 1);
        chk("R3 nmi alt", alt_op, 3'b101);
        ack();
        load(inh);
        chk("R3 nmi exit", exc_active, 0);
        nmi_n = 1'b0;
        tick(4);
        load(inh);
        chk("R3 held nmi entry", exc_active, 1);
        ack();
        load(inh);
        chk("R3 held nmi exit", exc_active, 0);
        load(inh);
        chk("R3 level no retrigger", exc_active, 0);
        chk("R3 level no inhibit", inh, 0);
        nmi_n = 1'b1;
        tick(4);
    endtask

    task automatic t_nmi_with_irq();
        logic inh;
        irq_n = 1'b0;
        nmi_n = 1'b0;
        tick(4);
        load(inh);
        chk("R6 both alt", alt_op, 3'b001);
        chk("R6 both entry", exc_active, 1);
        ack();
        irq_mask = 1'b1;
        load(inh);
        chk("R6 nmi consumed", exc_active, 0);
        irq_n = 1'b1;
        nmi_n = 1'b1;
        irq_mask = 1'b0;
        tick(4);
    endtask

    task automatic t_vector();
        vec_code = 4'hC; #1 chk("R10 reset vec", vec_lo, 8'hFC);
        vec_code = 4'hA; #1 chk("R10 nmi vec", vec_lo, 8'hFA);
        vec_code = 4'hE; #1 chk("R10 irq vec", vec_lo, 8'hFE);
        vec_code = 4'h3; #1 chk("R10 other vec", vec_lo, 8'hF3);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        t_reset_hold();
        t_irq_and_nested_nmi();
        t_nmi_pending();
        t_nmi_with_irq();
        t_vector();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule